// File: doc/BRIEF.md
# Reloadable Shift-Add FIR Filter

This block is a seven-tap, fully parallel FIR filter for signed 8-bit samples in Q1.7 format. It has no multipliers. Each coefficient is held as a raw 8-bit Q1.7 word. The bits of those words steer per-tap select muxes. For every bit position, a small adder tree sums the delayed samples whose coefficient has that bit set, which gives eight bit-plane partial sums. A shift-add stage then weights each partial sum by its bit position and subtracts the sign-bit plane. The result is the exact convolution, in Q5.14, one result per accepted sample.

Samples enter on a valid/ready stream and results leave on a valid/ready stream. The whole pipeline advances together, and only when its output register is empty or is being drained. Holding `m_ready` low therefore freezes every stage and deasserts `s_ready` while a result is pending. A new set of seven coefficients is written in one strobe. Nothing derived from the coefficients has to be recomputed, and every tap switches to the new set on the same edge.

Top module: `shiftadd_fir`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `m_valid` is 0 and `s_ready` is 1. All active coefficients reset to zero, so samples filtered before any load produce the result 0.
- R2: For each accepted sample x[n], the output is y = sum over k = 0..6 of c_k * x[n-k]. Here c_k is the signed integer in `coef_words[8k+7:8k]`, and tap 0 pairs with the newest sample. Both factors are treated as integers, so `m_data` is the 19-bit two's-complement value of y, with 14 fractional bits.
- R3: With `m_ready` held high, a sample accepted on clock edge T yields `m_valid` high after edge T+2 and not before.
- R4: `s_ready` is 1 exactly when `m_valid` is 0 or `m_ready` is 1. While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_data` hold their values.
- R5: Exactly one result is produced per accepted sample, in acceptance order. Idle input cycles produce no result.
- R6: A `coef_load` pulse captured on edge E latches all seven words of `coef_words` together. Samples accepted on edge E or earlier use the old set, and samples accepted on edge E+1 or later use the new set, provided the output is not stalled during that window. No result mixes the two sets.
- R7: Coefficient bit 7 has weight -1 and bits 6..0 have weights 1/2..1/128. The code 0x80 therefore acts as -1.0. Seven taps of 0x80 driven with the sample -128 give +114688 without overflow.
- R8: The delay line shifts only on accepted samples. Cycles with `s_valid` low, and stalled cycles, leave the sample history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Filter can accept a sample this cycle |
| s_data | input | 8 | Input sample, signed Q1.7 |
| coef_load | input | 1 | Strobe that latches a whole coefficient set |
| coef_words | input | 56 | Seven signed Q1.7 coefficients, tap k in bits 8k+7..8k |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream accepts the result |
| m_data | output | 19 | Full-precision result, signed Q5.14 |

## Verification
When the output is not stalled, a result is due two edges after its sample is accepted. While a result is stalled, it must be unchanged at every cycle until `m_ready` returns. A coefficient load affects samples accepted from the edge after the load onward. The bench drives and samples at the falling edge. It models acceptance and output transfers from the handshake levels seen just before each rising edge, and it queues the expected results at acceptance time, so every comparison lines up with the real transfer cycle. Coefficient reloads are issued only in stretches with `m_ready` high, which keeps the one-edge switching rule exact.

// File: rtl/fir_pkg.sv
package fir_pkg;

  localparam int FIR_TAPS_DEF = 7;
  localparam int FIR_DW_DEF   = 8;
  localparam int FIR_CW_DEF   = 8;

  // occupancy flags of the three pipeline registers
  typedef struct packed {
    logic line_v;   // delay line holds a fresh sample
    logic plane_v;  // bit-plane sums hold a fresh set
    logic out_v;    // output register holds a result
  } fir_vld_t;

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int TAPS = 7,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [DW-1:0]      din,
  output logic [TAPS*DW-1:0] taps_o
);

  logic [DW-1:0] stage_q [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) stage_q[k] <= '0;
    end else if (shift_en) begin
      stage_q[0] <= din;
      for (int k = 1; k < TAPS; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_out
    assign taps_o[k*DW +: DW] = stage_q[k];
  end

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int TAPS = 7,
  parameter int CW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TAPS*CW-1:0] words_i,
  output logic [TAPS*CW-1:0] active_o
);

  logic [TAPS*CW-1:0] shadow_q;
  logic [TAPS*CW-1:0] active_q;

  // shadow captures a full set; active copies it whole one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (load) shadow_q <= words_i;
      active_q <= shadow_q;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/fir_bitplane.sv
module fir_bitplane #(
  parameter int TAPS = 7,
  parameter int DW   = 8,
  parameter int PW   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [TAPS*DW-1:0] taps_i,
  input  logic [TAPS-1:0]    sel_i,
  output logic [PW-1:0]      psum_o
);

  logic signed [PW-1:0] term [TAPS];
  logic signed [PW-1:0] sum_c;
  logic signed [PW-1:0] psum_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_mux
    assign term[k] = sel_i[k]
                   ? {{(PW-DW){taps_i[k*DW+DW-1]}}, taps_i[k*DW +: DW]}
                   : '0;
  end

  always_comb begin
    sum_c = '0;
    for (int k = 0; k < TAPS; k++) sum_c = sum_c + term[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  psum_q <= '0;
    else if (en) psum_q <= sum_c;
  end

  assign psum_o = psum_q;

endmodule

// File: rtl/fir_shift_combine.sv
module fir_shift_combine #(
  parameter int CW = 8,
  parameter int PW = 11,
  parameter int OW = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CW*PW-1:0] psum_i,
  output logic [OW-1:0]    y_o
);

  logic signed [OW-1:0] scaled [CW];
  logic signed [OW-1:0] acc_c;
  logic signed [OW-1:0] y_q;

  for (genvar j = 0; j < CW; j++) begin : g_scale
    logic signed [OW-1:0] ext;
    assign ext       = {{(OW-PW){psum_i[j*PW+PW-1]}}, psum_i[j*PW +: PW]};
    assign scaled[j] = ext <<< j;
  end

  // top plane is the sign bit of every coefficient: weight -2^(CW-1)
  always_comb begin
    acc_c = '0;
    for (int j = 0; j < CW - 1; j++) acc_c = acc_c + scaled[j];
    acc_c = acc_c - scaled[CW-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= acc_c;
  end

  assign y_o = y_q;

endmodule

// File: rtl/shiftadd_fir.sv
module shiftadd_fir
  import fir_pkg::*;
#(
  parameter int TAPS = FIR_TAPS_DEF,
  parameter int DW   = FIR_DW_DEF,
  parameter int CW   = FIR_CW_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DW-1:0]        s_data,
  input  logic                 coef_load,
  input  logic [TAPS*CW-1:0]   coef_words,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [DW+CW+$clog2(TAPS)-1:0] m_data
);

  localparam int GROW = $clog2(TAPS);
  localparam int PW   = DW + GROW;
  localparam int OW   = DW + CW + GROW;

  fir_vld_t           vld_q;
  logic               advance;
  logic               accept;
  logic [TAPS*DW-1:0] tap_bus;
  logic [TAPS*CW-1:0] coef_active;
  logic [CW*PW-1:0]   psum_bus;

  // whole pipeline moves together when the output slot frees up
  assign advance = !vld_q.out_v || m_ready;
  assign accept  = s_valid && advance;
  assign s_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (advance) begin
      vld_q.line_v  <= accept;
      vld_q.plane_v <= vld_q.line_v;
      vld_q.out_v   <= vld_q.plane_v;
    end
  end

  fir_tap_line #(.TAPS(TAPS), .DW(DW)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (s_data),
    .taps_o   (tap_bus)
  );

  fir_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (coef_load),
    .words_i  (coef_words),
    .active_o (coef_active)
  );

  for (genvar j = 0; j < CW; j++) begin : g_plane
    logic [TAPS-1:0] sel;
    for (genvar k = 0; k < TAPS; k++) begin : g_sel
      assign sel[k] = coef_active[k*CW + j];
    end
    fir_bitplane #(.TAPS(TAPS), .DW(DW), .PW(PW)) u_bp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (advance),
      .taps_i (tap_bus),
      .sel_i  (sel),
      .psum_o (psum_bus[j*PW +: PW])
    );
  end

  fir_shift_combine #(.CW(CW), .PW(PW), .OW(OW)) u_comb (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (advance),
    .psum_i (psum_bus),
    .y_o    (m_data)
  );

  assign m_valid = vld_q.out_v;

endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
  parameter int TAPS = 7,
  parameter int CW   = 8,
  parameter int OW   = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic               m_valid,
  input logic               m_ready,
  input logic [OW-1:0]      m_data,
  input logic               coef_load,
  input logic [TAPS*CW-1:0] active
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!m_valid && s_ready));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) ##1 m_ready |=> ##1 m_valid);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> m_valid);

  assert_coef_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(coef_load, 2) |-> $stable(active));

endmodule

bind shiftadd_fir fir_checker #(.TAPS(TAPS), .CW(CW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .coef_load (coef_load),
  .active    (coef_active)
);

// File: tb/tb_shiftadd_fir.sv
module tb_shiftadd_fir;

  localparam int CLK_PERIOD   = 10;
  localparam int TAPS         = 7;
  localparam int DW           = 8;
  localparam int CW           = 8;
  localparam int OW           = 19;
  localparam int WATCHDOG_CYC = 50000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               s_valid;
  logic               s_ready;
  logic [DW-1:0]      s_data;
  logic               coef_load;
  logic [TAPS*CW-1:0] coef_words;
  logic               m_valid;
  logic               m_ready;
  logic [OW-1:0]      m_data;

  shiftadd_fir dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_data     (s_data),
    .coef_load  (coef_load),
    .coef_words (coef_words),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  int    hist   [TAPS];
  int    shad_m [TAPS];
  int    act_m  [TAPS];
  int    exp_q  [$];
  string tag = "R1";
  bit    hold_pend = 1'b0;
  logic [OW-1:0] hold_val;
  int    last_out = 0;

  function automatic int s8(input logic [7:0] b);
    return int'($signed(b));
  endfunction

  function automatic int ref_out();
    int acc = 0;
    for (int k = 0; k < TAPS; k++) acc += hist[k] * act_m[k];
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // evaluates handshakes just before the coming rising edge, then steps
  task automatic cycle();
    int got;
    int e;
    #1;
    got = int'($signed(m_data));
    if (hold_pend)
      check(m_valid === 1'b1 && m_data === hold_val, "R4", got, int'($signed(hold_val)));
    hold_pend = m_valid && !m_ready;
    hold_val  = m_data;
    check(s_ready === (!m_valid || m_ready), "R4", int'(s_ready), int'(!m_valid || m_ready));
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", got, 0);
      end else begin
        e = exp_q.pop_front();
        check(got == e, tag, got, e);
        last_out = got;
      end
    end
    for (int k = 0; k < TAPS; k++) act_m[k] = shad_m[k];
    if (coef_load)
      for (int k = 0; k < TAPS; k++) shad_m[k] = s8(coef_words[k*CW +: CW]);
    if (s_valid && s_ready) begin
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = s8(s_data);
      exp_q.push_back(ref_out());
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input int x);
    s_valid = 1'b1;
    s_data  = 8'(x);
    cycle();
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    s_valid = 1'b0;
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic load(input logic [TAPS*CW-1:0] w);
    coef_words = w;
    coef_load  = 1'b1;
    cycle();
    coef_load  = 1'b0;
  endtask

  function automatic logic [TAPS*CW-1:0] rand_set();
    logic [TAPS*CW-1:0] w;
    for (int k = 0; k < TAPS; k++) w[k*CW +: CW] = 8'($urandom);
    return w;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h5EED_F1A7);
    for (int k = 0; k < TAPS; k++) begin
      hist[k] = 0; shad_m[k] = 0; act_m[k] = 0;
    end
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0;
    coef_load = 1'b0; coef_words = '0; m_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(m_valid === 1'b0 && s_ready === 1'b1, "R1", int'(m_valid), 0);
    rst_n = 1'b1;
    #1;
    check(m_valid === 1'b0 && s_ready === 1'b1, "R1", int'(m_valid), 0);
    @(negedge clk);

    // R1: zero coefficients after reset give zero results
    tag = "R1";
    send(100); send(-5); idle(4);
    check(last_out == 0, "R1", last_out, 0);

    // mixed set incl. -1 (0x80) and +127/128 (0x7F); tap6..tap0
    load({8'h55, 8'h00, 8'hC0, 8'h01, 8'h40, 8'h7F, 8'h80});
    idle(2);

    // R3: single sample, output exactly two edges later
    tag = "R3";
    s_valid = 1'b1; s_data = 8'd127;
    cycle();
    s_valid = 1'b0;
    check(m_valid === 1'b0, "R3", int'(m_valid), 0);
    cycle();
    check(m_valid === 1'b0, "R3", int'(m_valid), 0);
    cycle();
    check(m_valid === 1'b1, "R3", int'(m_valid), 1);

    // R2: impulse response walks through every coefficient, then random data
    tag = "R2";
    for (int i = 0; i < 6; i++) send(0);
    for (int i = 0; i < 24; i++) send(int'($signed(8'($urandom))));
    idle(4);

    // R7: all taps -1, most negative sample
    load({TAPS{8'h80}});
    idle(2);
    tag = "R7";
    for (int i = 0; i < TAPS; i++) send(-128);
    idle(4);
    check(last_out == 114688, "R7", last_out, 114688);

    // R8: gaps between samples must not shift the history
    tag = "R8";
    send(3); idle(3); send(-7); idle(2); send(50); idle(1); send(-128);
    send(127); idle(5); send(1); idle(4);

    // R4 / R5: random valid and back-pressure, fixed coefficients
    load(rand_set());
    idle(2);
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      s_valid = ($urandom % 10) < 7;
      s_data  = 8'($urandom);
      m_ready = ($urandom % 2) == 0;
      cycle();
    end
    s_valid = 1'b0; m_ready = 1'b1;
    idle(6);

    // R6: reloads in the middle of a continuous stream
    tag = "R6";
    for (int i = 0; i < 80; i++) begin
      s_valid    = 1'b1;
      s_data     = 8'($urandom);
      coef_load  = (i == 20) || (i == 45) || (i == 46);
      if (coef_load) coef_words = rand_set();
      cycle();
    end
    coef_load = 1'b0;
    idle(6);

    check(exp_q.size() == 0, "R5", exp_q.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R5 watchdog: actual 0 expected 1 (run did not complete)");
      summary();
      $finish;
    end
  end

endmodule